// File: doc/BRIEF.md
# SPI Flash Software Byte Port

This block lets software talk directly to a SPI flash device, one byte stream at a time. While the chip's control word selects the software-driven mode, every bus write to the chip's window is serialised onto MOSI, and every bus read clocks bytes in from MISO.

The window behaves as a byte FIFO. The address within the window only matters for checking alignment. Chip select is not tied to bus transactions. Software lowers and raises it through a stop bit in the control word. A typical command is built from several steps:

1. Clear the stop bit.
2. Write the opcode and address bytes.
3. Write 0xFF dummy bytes if the command needs them.
4. Read the reply bytes.
5. Set the stop bit again.

Top module: `spi_user_port`

## Requirements
- R1: An access is carried out only while ctrl_reg[1:0] equals 3 (software mode). In any other mode a request is dropped: no SCK edge occurs and bus_ready stays high.
- R2: Chip select is driven as follows:
  - spi_cs_n is high out of reset.
  - When idle, spi_cs_n goes low one cycle after software mode is selected with ctrl_reg[2] (stop bit) clear.
  - When idle, spi_cs_n goes high one cycle after ctrl_reg[2] is set or software mode is left.
- R3: A write sends the bytes of bus_wdata starting at lane 0 (bits 7:0) and moving upward. Each byte goes out MSB first. SCK idles low and MOSI is valid at each SCK rising edge (SPI mode 0).
- R4: bus_offs does not change the bytes sent. It is used only for the alignment check.
- R5: bus_size encodes the width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. A request is dropped (no SPI activity, bus_ready stays high) in either of these cases:
  - bus_size is 3.
  - bus_offs is not a multiple of the access size.
- R6: A write is carried out only when cfg_we[chip_sel] is 1. This bit is the chip's write-enable bit, taken from config bit 16 + chip index. Otherwise the write is dropped. Reads do not depend on this bit.
- R7: A read of N bytes shifts out N bytes of 0xFF and captures MISO MSB first. The first received byte is placed in lane 0, and the lanes above N bytes read as zero.
- R8: bus_ready is low from the cycle after an accepted request for exactly N*(16*SCK_HALF+2) cycles. A request is accepted on a clock edge where bus_valid is high, bus_ready is high and the access is legal.
- R9: If the stop bit is set or software mode is left while an access is in progress, all of that access's bytes still go out, and spi_cs_n stays low until bus_ready returns high.
- R10: 2-byte accesses send or receive exactly two bytes in lane order.
- R11: spi_sck is low whenever bus_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request strobe, sampled while bus_ready is high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offs | input | 2 | Low byte-offset bits of the window address |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 32 | Write data, lane 0 sent first |
| bus_rdata | output | 32 | Read data, valid once bus_ready returns high |
| bus_ready | output | 1 | High when idle |
| ctrl_reg | input | 3 | Chip control bits: [1:0] mode, [2] stop |
| chip_sel | input | CS_W | Index of the chip this window serves |
| cfg_we | input | NUM_CS | Per-chip write-enable bits (config bits 16 and up) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench sends writes of 1, 2 and 4 bytes with distinct lane values and varied offsets. This shows that lane order is honoured and that the offset does not affect the stream. Reads are answered by a bench SPI responder whose byte values depend on their position. This separates lane placement from bit order, and shows that 0xFF is what goes out on MOSI.

Illegal requests are issued and must leave both bus_ready and the SPI pins quiet. These cover:
- misaligned offsets and size code 3,
- a cleared write-enable bit, including a chip index that selects a different bit,
- a mode other than software mode.

In a further case, software mode is left in the middle of a word write. This tells a chip select that holds until the access ends apart from one that drops at once.

// File: rtl/spi_user_pkg.sv
package spi_user_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_WAIT = 2'd2
    } acc_state_e;

    localparam logic [1:0] MODE_SW   = 2'd3;
    localparam int         STOP_POS  = 2;
    localparam logic [1:0] SIZE_BYTE = 2'd0;
    localparam logic [1:0] SIZE_HALF = 2'd1;
    localparam logic [1:0] SIZE_WORD = 2'd2;
endpackage

// File: rtl/spi_user_gate.sv
module spi_user_gate
    import spi_user_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int CS_W   = 2
) (
    input  logic [2:0]        ctrl_reg,
    input  logic [CS_W-1:0]   chip_sel,
    input  logic [NUM_CS-1:0] cfg_we,
    input  logic [1:0]        size,
    input  logic [1:0]        offs,
    input  logic              is_write,
    output logic              legal,
    output logic [1:0]        last_idx
);
    logic sw_mode;
    logic aligned;
    logic we_ok;

    always_comb begin
        sw_mode = (ctrl_reg[1:0] == MODE_SW);
        we_ok   = (int'(chip_sel) < NUM_CS) && cfg_we[chip_sel];
        case (size)
            SIZE_BYTE: begin aligned = 1'b1;           last_idx = 2'd0; end
            SIZE_HALF: begin aligned = !offs[0];       last_idx = 2'd1; end
            SIZE_WORD: begin aligned = (offs == 2'd0); last_idx = 2'd3; end
            default:   begin aligned = 1'b0;           last_idx = 2'd0; end
        endcase
        legal = sw_mode && aligned && (!is_write || we_ok);
    end
endmodule

// File: rtl/spi_user_shifter.sv
module spi_user_shifter #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       done
);
    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic [2:0]       bit_idx;
        logic [DIV_W-1:0] div;
        logic             done;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.busy    = 1'b1;
            d.sck     = 1'b0;
            d.sh      = tx_byte;
            d.bit_idx = 3'd0;
            d.div     = '0;
        end else if (q.busy) begin
            if (q.div == DIV_LAST) begin
                d.div = '0;
                if (!q.sck) begin
                    d.sck = 1'b1;
                    d.rx  = {q.rx[6:0], miso};
                end else begin
                    d.sck = 1'b0;
                    if (q.bit_idx == 3'd7) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.bit_idx = q.bit_idx + 3'd1;
                        d.sh      = {q.sh[6:0], 1'b0};
                    end
                end
            end else begin
                d.div = q.div + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck     = q.sck;
    assign mosi    = q.sh[7];
    assign rx_byte = q.rx;
    assign done    = q.done;
endmodule

// File: rtl/spi_user_port.sv
module spi_user_port
    import spi_user_pkg::*;
#(
    parameter int NUM_CS   = 3,
    parameter int SCK_HALF = 2,
    localparam int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_offs,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    input  logic [2:0]        ctrl_reg,
    input  logic [CS_W-1:0]   chip_sel,
    input  logic [NUM_CS-1:0] cfg_we,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    typedef struct packed {
        acc_state_e  st;
        logic        wr;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic [1:0]  idx;
        logic [1:0]  last;
        logic        cs_act;
    } port_t;

    port_t q, d;

    logic       legal;
    logic [1:0] last_idx;
    logic       shf_start;
    logic [7:0] shf_tx;
    logic [7:0] shf_rx;
    logic       shf_done;

    spi_user_gate #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_gate (
        .ctrl_reg (ctrl_reg),
        .chip_sel (chip_sel),
        .cfg_we   (cfg_we),
        .size     (bus_size),
        .offs     (bus_offs),
        .is_write (bus_write),
        .legal    (legal),
        .last_idx (last_idx)
    );

    spi_user_shifter #(.SCK_HALF(SCK_HALF)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (shf_start),
        .tx_byte (shf_tx),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .rx_byte (shf_rx),
        .done    (shf_done)
    );

    always_comb begin
        d         = q;
        shf_start = 1'b0;
        shf_tx    = q.wr ? q.wdata[{q.idx, 3'b000} +: 8] : 8'hFF;
        case (q.st)
            ACC_IDLE: begin
                if (bus_valid && legal) begin
                    d.st    = ACC_LOAD;
                    d.wr    = bus_write;
                    d.wdata = bus_wdata;
                    d.idx   = 2'd0;
                    d.last  = last_idx;
                    if (!bus_write) d.rdata = '0;
                end
            end
            ACC_LOAD: begin
                shf_start = 1'b1;
                d.st      = ACC_WAIT;
            end
            ACC_WAIT: begin
                if (shf_done) begin
                    if (!q.wr) d.rdata[{q.idx, 3'b000} +: 8] = shf_rx;
                    if (q.idx == q.last) begin
                        d.st = ACC_IDLE;
                    end else begin
                        d.idx = q.idx + 2'd1;
                        d.st  = ACC_LOAD;
                    end
                end
            end
            default: d.st = ACC_IDLE;
        endcase
        d.cs_act = ((ctrl_reg[1:0] == MODE_SW) && !ctrl_reg[STOP_POS])
                 || ((q.st != ACC_IDLE) && q.cs_act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ACC_IDLE, default: '0};
        else        q <= d;
    end

    assign bus_ready = (q.st == ACC_IDLE);
    assign bus_rdata = q.rdata;
    assign spi_cs_n  = !q.cs_act;
endmodule

// File: rtl/spi_user_port_chk.sv
module spi_user_port_chk #(
    parameter int NUM_CS = 3,
    parameter int CS_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [1:0]        bus_offs,
    input logic [1:0]        bus_size,
    input logic              bus_ready,
    input logic [2:0]        ctrl_reg,
    input logic [CS_W-1:0]   chip_sel,
    input logic [NUM_CS-1:0] cfg_we,
    input logic              spi_cs_n,
    input logic              spi_sck
);
    logic misaligned;
    logic we_bit;
    logic sw_mode;
    logic ok_req;

    always_comb begin
        misaligned = (bus_size == 2'd3)
                   || ((bus_size == 2'd1) && bus_offs[0])
                   || ((bus_size == 2'd2) && (bus_offs != 2'd0));
        we_bit  = (int'(chip_sel) < NUM_CS) && cfg_we[chip_sel];
        sw_mode = (ctrl_reg[1:0] == 2'd3);
        ok_req  = sw_mode && !misaligned && (!bus_write || we_bit);
    end

    assert_mode_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_valid && !sw_mode) |=> bus_ready);

    assert_cs_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_mode && !ctrl_reg[2]) |=> !spi_cs_n);

    assert_misalign_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_valid && misaligned) |=> bus_ready);

    assert_we_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_valid && bus_write && !we_bit) |=> bus_ready);

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_valid && ok_req) |=> !bus_ready);

    assert_cs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready && !spi_cs_n) |=> !spi_cs_n);

    assert_sck_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> !spi_sck);
endmodule

bind spi_user_port spi_user_port_chk #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_offs  (bus_offs),
    .bus_size  (bus_size),
    .bus_ready (bus_ready),
    .ctrl_reg  (ctrl_reg),
    .chip_sel  (chip_sel),
    .cfg_we    (cfg_we),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck)
);

// File: tb/spi_user_port_tb.sv
module spi_user_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CS     = 3;
    localparam int CS_W       = 2;
    localparam int SCK_HALF   = 2;
    localparam int BYTE_CYC   = 16 * SCK_HALF + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_offs = 2'd0;
    logic [1:0]  bus_size = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [2:0]  ctrl_reg = 3'b111;
    logic [CS_W-1:0]   chip_sel = '0;
    logic [NUM_CS-1:0] cfg_we = '0;
    logic        spi_cs_n;
    logic        spi_sck;
    logic        spi_mosi;
    logic        spi_miso;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_user_port #(.NUM_CS(NUM_CS), .SCK_HALF(SCK_HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_offs(bus_offs), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .ctrl_reg(ctrl_reg),
        .chip_sel(chip_sel), .cfg_we(cfg_we), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // SPI responder: byte k of the stream answers with resp(k)
    function automatic logic [7:0] resp(input int k);
        return 8'(k * 29) ^ 8'h5A;
    endfunction

    logic [7:0] mosi_q[$];
    logic [7:0] s_bits = '0;
    int         s_cnt = 0;
    int         s_idx = 0;
    logic [7:0] s_cur;

    always_comb s_cur = resp(s_idx);
    assign spi_miso = s_cur[3'(7 - s_cnt)];

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            s_bits = {s_bits[6:0], spi_mosi};
            s_cnt++;
            if (s_cnt == 8) begin
                mosi_q.push_back(s_bits);
                s_cnt = 0;
                s_idx++;
            end
        end
    end

    // Behavioural reference for ready and chip select
    bit m_ready = 1'b1;
    bit m_cs    = 1'b0;
    int m_left  = 0;

    function automatic bit req_legal();
        bit ok;
        ok = (ctrl_reg[1:0] == 2'd3);
        if (bus_size == 2'd3) ok = 0;
        if (bus_size == 2'd1 && bus_offs[0]) ok = 0;
        if (bus_size == 2'd2 && bus_offs != 2'd0) ok = 0;
        if (bus_write && !(int'(chip_sel) < NUM_CS && cfg_we[chip_sel])) ok = 0;
        return ok;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ready = 1'b1; m_cs = 1'b0; m_left = 0;
        end else begin
            bit cs_next;
            cs_next = ((ctrl_reg[1:0] == 2'd3) && !ctrl_reg[2]) || (!m_ready && m_cs);
            if (m_ready && bus_valid && req_legal()) begin
                m_left  = (bus_size == 2'd0 ? 1 : bus_size == 2'd1 ? 2 : 4) * BYTE_CYC;
                m_ready = 1'b0;
            end else if (!m_ready) begin
                m_left--;
                if (m_left == 0) m_ready = 1'b1;
            end
            m_cs = cs_next;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(bus_ready == m_ready, "R8 ready per cycle", 32'(bus_ready), 32'(m_ready));
            chk(spi_cs_n == !m_cs, "R2/R9 cs_n per cycle", 32'(spi_cs_n), 32'(!m_cs));
        end
    end

    task automatic access(input bit wr, input logic [1:0] offs, input logic [1:0] size, input logic [31:0] wd);
        @(negedge clk);
        bus_write = wr; bus_offs = offs; bus_size = size; bus_wdata = wd; bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
        while (!bus_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_bytes(input string tag, input int n, input logic [31:0] packed_exp);
        chk(mosi_q.size() == n, tag, 32'(mosi_q.size()), 32'(n));
        for (int i = 0; i < n && i < mosi_q.size(); i++)
            chk(mosi_q[i] == packed_exp[i*8 +: 8], tag, 32'(mosi_q[i]), 32'(packed_exp[i*8 +: 8]));
        mosi_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int k0;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R2 reset cs_n", 32'(spi_cs_n), 1);
        chk(bus_ready == 1'b1, "R8 reset ready", 32'(bus_ready), 1);
        chk(spi_sck == 1'b0, "R11 reset sck", 32'(spi_sck), 0);
        chk(bus_rdata == 32'h0, "R7 reset rdata", bus_rdata, 0);
        rst_n = 1'b1;
        cfg_we = 3'b001;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R2 stop bit holds cs_n high", 32'(spi_cs_n), 1);
        ctrl_reg = 3'b011;
        repeat (2) @(negedge clk);
        chk(spi_cs_n == 1'b0, "R2 cleared stop asserts cs_n", 32'(spi_cs_n), 0);

        access(1, 2'd0, 2'd2, 32'h33221103);
        expect_bytes("R3 word write lane order", 4, 32'h33221103);

        access(1, 2'd3, 2'd0, 32'h000000A5);
        expect_bytes("R4 offset ignored byte write", 1, 32'h000000A5);
        access(1, 2'd0, 2'd0, 32'h000000A5);
        expect_bytes("R4 offset zero byte write", 1, 32'h000000A5);
        access(1, 2'd2, 2'd1, 32'h0000BEEF);
        expect_bytes("R10 half write", 2, 32'h0000BEEF);

        k0 = s_idx;
        access(0, 2'd0, 2'd2, 32'h0);
        chk(bus_rdata == {resp(k0+3), resp(k0+2), resp(k0+1), resp(k0)}, "R7 word read",
            bus_rdata, {resp(k0+3), resp(k0+2), resp(k0+1), resp(k0)});
        expect_bytes("R7 read sends 0xFF", 4, 32'hFFFFFFFF);

        k0 = s_idx;
        access(0, 2'd1, 2'd0, 32'h0);
        chk(bus_rdata == {24'h0, resp(k0)}, "R7 byte read upper lanes zero", bus_rdata, {24'h0, resp(k0)});
        expect_bytes("R7 byte read sends 0xFF", 1, 32'h000000FF);

        k0 = s_idx;
        access(0, 2'd2, 2'd1, 32'h0);
        chk(bus_rdata == {16'h0, resp(k0+1), resp(k0)}, "R10 half read", bus_rdata, {16'h0, resp(k0+1), resp(k0)});
        expect_bytes("R10 half read sends 0xFF", 2, 32'h0000FFFF);

        access(1, 2'd2, 2'd2, 32'h12345678);
        expect_bytes("R5 misaligned word dropped", 0, 32'h0);
        access(1, 2'd1, 2'd1, 32'h12345678);
        expect_bytes("R5 misaligned half dropped", 0, 32'h0);
        access(1, 2'd0, 2'd3, 32'h12345678);
        expect_bytes("R5 size code 3 dropped", 0, 32'h0);

        cfg_we = 3'b000;
        access(1, 2'd0, 2'd0, 32'h0000003C);
        expect_bytes("R6 write without enable dropped", 0, 32'h0);
        k0 = s_idx;
        access(0, 2'd0, 2'd0, 32'h0);
        chk(bus_rdata == {24'h0, resp(k0)}, "R6 read without enable", bus_rdata, {24'h0, resp(k0)});
        expect_bytes("R6 read without enable runs", 1, 32'h000000FF);
        cfg_we = 3'b010;
        access(1, 2'd0, 2'd0, 32'h00000077);
        expect_bytes("R6 other chip enable bit ignored", 0, 32'h0);
        chip_sel = 2'd1;
        access(1, 2'd0, 2'd0, 32'h00000077);
        expect_bytes("R6 chip 1 enable bit honoured", 1, 32'h00000077);
        chip_sel = 2'd0;
        cfg_we = 3'b001;

        ctrl_reg = 3'b000;
        repeat (2) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R2 leaving mode deasserts cs_n", 32'(spi_cs_n), 1);
        access(1, 2'd0, 2'd0, 32'h00000011);
        expect_bytes("R1 non-software mode dropped", 0, 32'h0);

        ctrl_reg = 3'b011;
        repeat (2) @(negedge clk);
        @(negedge clk);
        bus_write = 1; bus_offs = 0; bus_size = 2'd2; bus_wdata = 32'hD4C3B2A1; bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
        repeat (10) @(negedge clk);
        ctrl_reg = 3'b100;
        chk(bus_ready == 1'b0, "R9 access still busy", 32'(bus_ready), 0);
        while (!bus_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        expect_bytes("R9 access completes after leaving mode", 4, 32'hD4C3B2A1);
        chk(spi_cs_n == 1'b1, "R9 cs_n released after access", 32'(spi_cs_n), 1);

        ctrl_reg = 3'b011;
        repeat (2) @(negedge clk);
        ctrl_reg = 3'b111;
        repeat (2) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R2 stop bit ends command", 32'(spi_cs_n), 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule